// File: doc/BRIEF.md
# Two-Byte Instruction Prefetch Engine

This block connects the byte-wide code fetch port of an 8-bit processor core to a flash array that returns 16 bits per access. It reads code as aligned pairs of bytes and keeps one pair in a buffer. While the core walks through straight-line code, the engine starts the read of the following pair early enough that the core never waits. When the core asks for a byte that is neither buffered nor being fetched, which is the case after a taken branch, the engine drops what it holds. It then reads the pair that contains the new target and holds the core until the byte arrives.

Flash access time is chosen by the `slowRead` input. At 0 an access takes one clock, which suits system clocks up to 25 MHz. At 1 an access takes two clocks, which suits clocks from 25 MHz up to 50 MHz. An 8-bit control register holds the prefetch enable and a paired-write mode bit. The paired-write bit is passed on to the flash programming logic: at 1 that logic commits software flash writes two bytes at a time, and at 0 it writes each byte on its own. With prefetch disabled, the engine reads flash directly for every byte and keeps nothing between requests.

Top module: `prefetch_engine`

## Requirements
- R1: After reset, `cfgRdData` reads 0x20 (prefetch enabled), `pairWrite` is 0, and while `reqValid` is low, `rspValid` and `flRead` are 0.
- R2: In the control register, bit 5 is the prefetch enable (1 = enabled) and bit 0 is the paired-write mode. Bits 7:6 and 4:1 always read 0, and writes to them have no effect. Without a write, the register keeps its value.
- R3: `pairWrite` always equals control register bit 0.
- R4: `flAddr` is the byte address shifted right by one. The byte at an even address is `flData[7:0]` and the byte at an odd address is `flData[15:8]`.
- R5: With `slowRead` = 0, a flash read keeps `flRead` high for one cycle. With `slowRead` = 1 it keeps `flRead` high for two cycles, and `flAddr` does not change between them. `slowRead` may change only while prefetch is disabled.
- R6: With prefetch enabled, a run of sequential requests that starts at an even address has no stall cycles after its first byte, at either latency.
- R7: Any request that must be read from flash is answered after at most 1 stall cycle (`slowRead` = 0) or 2 stall cycles (`slowRead` = 1). This includes a branch that arrives while a prefetch is still in progress; that prefetch is abandoned.
- R8: A branch to an odd address delivers the high byte of the aligned pair first. The byte that follows waits 0 cycles when `slowRead` = 0 and 1 cycle when `slowRead` = 1.
- R9: With prefetch disabled, every byte, including the second byte of the same pair, waits the full latency: 1 stall cycle (`slowRead` = 0) or 2 stall cycles (`slowRead` = 1).
- R10: `rspValid` is high only when the requested byte is in the buffer, and `rspData` then equals the flash content at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core requests a code byte |
| reqAddr | input | ADDR_W | Byte address of the request |
| rspValid | output | 1 | Requested byte is present this cycle |
| rspData | output | 8 | Requested code byte |
| flRead | output | 1 | Flash read in progress |
| flAddr | output | ADDR_W-1 | Flash pair address |
| flData | input | 16 | Flash pair read data |
| slowRead | input | 1 | 0: one-cycle flash read, 1: two-cycle flash read |
| cfgWrEn | input | 1 | Control register write strobe |
| cfgWrData | input | 8 | Control register write data |
| cfgRdData | output | 8 | Control register read value |
| pairWrite | output | 1 | Paired-byte flash write mode |

## Verification
The assertions assume two things about the inputs. First, the core keeps `reqAddr` unchanged while it waits for `rspValid`: the stall bound and the flash-hold property count cycles only while the address stays the same. Second, `slowRead` changes only while the enable bit is 0. The bench meets the first assumption by holding every request until it is answered. It meets the second by changing the latency only inside a sequence that disables prefetch, idles two cycles, sets `slowRead` and then enables again. Random segments choose start addresses, lengths, gaps and mode changes. Directed runs cover even and odd branch targets, a branch that arrives during an in-progress two-cycle prefetch, and both disabled latencies.

// File: rtl/pfe_pkg.sv
package pfe_pkg;

  // Control register layout
  localparam int CFG_W       = 8;
  localparam int CFG_EN_BIT  = 5;
  localparam int CFG_PW_BIT  = 0;
  localparam logic [CFG_W-1:0] CFG_RESET = 8'h20;

  // Strobes from control to datapath
  typedef struct packed {
    logic startFetch;  // begin a flash read this cycle
    logic useNext;     // 1: read pair after buffer, 0: read requested pair
    logic loadBuf;     // flash data lands in the buffer at this edge
    logic dropBuf;     // invalidate buffer after delivery (unbuffered mode)
  } pfeStrobes_t;

endpackage

// File: rtl/pfe_cfg_reg.sv
module pfe_cfg_reg
  import pfe_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  output logic             prefetchEn,
  output logic             pairWrite
);

  logic enReg;
  logic pwReg;
  logic unusedCfgBits;

  assign unusedCfgBits = ^{cfgWrData[7:6], cfgWrData[4:1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg <= CFG_RESET[CFG_EN_BIT];
      pwReg <= CFG_RESET[CFG_PW_BIT];
    end else if (cfgWrEn) begin
      enReg <= cfgWrData[CFG_EN_BIT];
      pwReg <= cfgWrData[CFG_PW_BIT];
    end
  end

  always_comb begin
    cfgRdData             = '0;
    cfgRdData[CFG_EN_BIT] = enReg;
    cfgRdData[CFG_PW_BIT] = pwReg;
  end

  assign prefetchEn = enReg;
  assign pairWrite  = pwReg;

  // R2: a write lands in the two live bits on the next cycle
  p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> (cfgRdData[CFG_EN_BIT] == $past(cfgWrData[CFG_EN_BIT])) &&
                (cfgRdData[CFG_PW_BIT] == $past(cfgWrData[CFG_PW_BIT])));

  // R2: without a write the register holds
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(cfgRdData));

endmodule

// File: rtl/pfe_ctrl.sv
module pfe_ctrl
  import pfe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqOdd,
  input  logic        hit,
  input  logic        fetchMatch,
  input  logic        prefetchEn,
  input  logic        slowRead,
  output pfeStrobes_t strobes,
  output logic        flRead,
  output logic        busy
);

  logic missNow;
  logic busyKeep;
  logic pfTrig;

  always_comb begin
    missNow  = reqValid && !hit;
    // a second read cycle continues unless a branch wants another pair
    busyKeep = busy && !(missNow && !fetchMatch);
    // fast reads prefetch when the high byte is consumed, slow reads on any hit
    pfTrig   = prefetchEn && reqValid && hit && (slowRead || reqOdd);

    strobes.startFetch = !busyKeep && (missNow || pfTrig);
    strobes.useNext    = !missNow;
    strobes.loadBuf    = busyKeep || (strobes.startFetch && !slowRead);
    strobes.dropBuf    = !prefetchEn && reqValid && hit;
    flRead             = strobes.startFetch || busyKeep;
  end

  always_ff @(posedge clk) begin
    if (!rstN) busy <= 1'b0;
    else       busy <= strobes.startFetch && slowRead;
  end

  // R7: a miss on the pair already in flight rides the running read
  p_keep_on_match_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqValid && !hit && fetchMatch) |-> (flRead && !strobes.startFetch));

  // R9: with prefetch off, reads are only ever started by a miss
  p_no_prefetch_when_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!prefetchEn && strobes.startFetch) |-> (reqValid && !hit));

endmodule

// File: rtl/pfe_datapath.sv
module pfe_datapath
  import pfe_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  pfeStrobes_t       strobes,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       flData,
  output logic              hit,
  output logic              fetchMatch,
  output logic              rspValid,
  output logic [7:0]        rspData,
  output logic [ADDR_W-2:0] flAddr
);

  localparam int PAIR_W = ADDR_W - 1;

  logic              bufValid;
  logic [PAIR_W-1:0] bufBase;
  logic [15:0]       bufData;
  logic [PAIR_W-1:0] fetchBase;
  logic [PAIR_W-1:0] reqPair;
  logic [PAIR_W-1:0] newPair;

  always_comb begin
    reqPair    = reqAddr[ADDR_W-1:1];
    newPair    = strobes.useNext ? (bufBase + PAIR_W'(1)) : reqPair;
    flAddr     = strobes.startFetch ? newPair : fetchBase;
    hit        = bufValid && (bufBase == reqPair);
    fetchMatch = (fetchBase == reqPair);
    rspValid   = reqValid && hit;
    rspData    = reqAddr[0] ? bufData[15:8] : bufData[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufValid  <= 1'b0;
      bufBase   <= '0;
      bufData   <= '0;
      fetchBase <= '0;
    end else begin
      if (strobes.startFetch) fetchBase <= newPair;
      if (strobes.loadBuf) begin
        bufValid <= 1'b1;
        bufBase  <= flAddr;
        bufData  <= flData;
      end else if (strobes.dropBuf) begin
        bufValid <= 1'b0;
      end
    end
  end

  // R10: a buffer reload is visible as the requested pair on the next cycle
  p_load_lands_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadBuf |=> (bufValid && bufBase == $past(flAddr)));

endmodule

// File: rtl/prefetch_engine.sv
module prefetch_engine
  import pfe_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic [7:0]        rspData,
  output logic              flRead,
  output logic [ADDR_W-2:0] flAddr,
  input  logic [15:0]       flData,
  input  logic              slowRead,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  output logic              pairWrite
);

  pfeStrobes_t strobes;
  logic        prefetchEn;
  logic        hit;
  logic        fetchMatch;
  logic        busy;

  pfe_cfg_reg u_cfg (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .cfgRdData (cfgRdData),
    .prefetchEn(prefetchEn),
    .pairWrite (pairWrite)
  );

  pfe_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqOdd    (reqAddr[0]),
    .hit       (hit),
    .fetchMatch(fetchMatch),
    .prefetchEn(prefetchEn),
    .slowRead  (slowRead),
    .strobes   (strobes),
    .flRead    (flRead),
    .busy      (busy)
  );

  pfe_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqValid  (reqValid),
    .reqAddr   (reqAddr),
    .flData    (flData),
    .hit       (hit),
    .fetchMatch(fetchMatch),
    .rspValid  (rspValid),
    .rspData   (rspData),
    .flAddr    (flAddr)
  );

  // Stall window checker: consecutive unanswered cycles on one address
  logic [1:0]        stallCnt;
  logic [ADDR_W-1:0] prevAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stallCnt <= '0;
      prevAddr <= '0;
    end else begin
      prevAddr <= reqAddr;
      if (reqValid && !rspValid) begin
        if (stallCnt != 2'd0 && reqAddr == prevAddr)
          stallCnt <= (stallCnt == 2'd3) ? 2'd3 : stallCnt + 2'd1;
        else
          stallCnt <= 2'd1;
      end else begin
        stallCnt <= 2'd0;
      end
    end
  end

  // R7: never more than two stall cycles on a held request
  p_stall_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    stallCnt != 2'd3);

  // R5: the second cycle of a slow read keeps the flash address
  p_flash_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $stable(reqAddr)) |-> (flRead && $stable(flAddr)));

  // R5: latency select stays put while prefetch is running
  p_latency_steady_r5: assert property (@(posedge clk) disable iff (!rstN)
    (prefetchEn && $past(prefetchEn)) |-> $stable(slowRead));

endmodule

// File: tb/prefetch_engine_tb.sv
module prefetch_engine_tb;

  localparam int ADDR_W = 10;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic [ADDR_W-1:0] reqAddr;
  logic              rspValid;
  logic [7:0]        rspData;
  logic              flRead;
  logic [ADDR_W-2:0] flAddr;
  logic [15:0]       flData;
  logic              slowRead;
  logic              cfgWrEn;
  logic [7:0]        cfgWrData;
  logic [7:0]        cfgRdData;
  logic              pairWrite;

  int checks = 0;
  int errors = 0;
  bit enMode;
  bit slowMode;

  always #2 clk = ~clk;

  function automatic logic [15:0] flashWord(input logic [ADDR_W-2:0] p);
    logic [7:0] lo;
    logic [7:0] hi;
    lo = p[7:0] * 8'd7 + {7'd0, p[8]} + 8'h13;
    hi = p[7:0] ^ 8'hA5 ^ {p[8], 7'd0};
    return {hi, lo};
  endfunction

  function automatic logic [7:0] byteAt(input logic [ADDR_W-1:0] a);
    logic [15:0] w;
    w = flashWord(a[ADDR_W-1:1]);
    return a[0] ? w[15:8] : w[7:0];
  endfunction

  // expected stalls for byte idx of a fresh sequential run
  function automatic int expStall(input int idx, input bit startOdd,
                                  input bit en, input bit slow);
    if (!en || idx == 0) return slow ? 2 : 1;
    if (idx == 1 && startOdd && slow) return 1;
    return 0;
  endfunction

  assign flData = flRead ? flashWord(flAddr) : 16'h0000;

  prefetch_engine #(.ADDR_W(ADDR_W)) u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqAddr  (reqAddr),
    .rspValid (rspValid),
    .rspData  (rspData),
    .flRead   (flRead),
    .flAddr   (flAddr),
    .flData   (flData),
    .slowRead (slowRead),
    .cfgWrEn  (cfgWrEn),
    .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData),
    .pairWrite(pairWrite)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [7:0] d);
    @(negedge clk);
    reqValid  = 1'b0;
    cfgWrEn   = 1'b1;
    cfgWrData = d;
    @(negedge clk);
    cfgWrEn   = 1'b0;
  endtask

  task automatic setMode(input bit en, input bit slow);
    cfgWrite(8'h00);
    idle(2);
    slowRead = slow;
    idle(1);
    cfgWrite(en ? 8'h20 : 8'h00);
    enMode   = en;
    slowMode = slow;
  endtask

  // exact: stalls and flash read cycles must equal expS; else stalls <= expS
  task automatic fetchByte(input logic [ADDR_W-1:0] a, input int expS,
                           input bit exact, input string req);
    int stalls = 0;
    int reads  = 0;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = a;
    #1;
    while (!rspValid && stalls < 8) begin
      if (flRead) reads++;
      if (stalls == 0 && exact)
        chk(flRead && flAddr == a[ADDR_W-1:1], "R4", "flash pair address",
            int'(flAddr), int'(a[ADDR_W-1:1]));
      stalls++;
      @(negedge clk);
      #1;
    end
    chk(rspValid, "R10", "response never arrived", int'(rspValid), 1);
    if (rspValid)
      chk(rspData == byteAt(a), "R10", "byte data", int'(rspData), int'(byteAt(a)));
    if (exact) begin
      chk(stalls == expS, req, "stall cycles", stalls, expS);
      chk(reads == expS, "R5", "flash read cycles while stalled", reads, expS);
    end else begin
      chk(stalls <= expS, "R7", "stall bound", stalls, expS);
    end
  endtask

  task automatic runLinear(input logic [ADDR_W-1:0] start, input int n,
                           input string req);
    for (int i = 0; i < n; i++)
      fetchByte(start + ADDR_W'(i), expStall(i, start[0], enMode, slowMode),
                1'b1, req);
  endtask

  initial begin
    int unsigned seed;
    seed      = $urandom(32'd1357);
    rstN      = 1'b0;
    reqValid  = 1'b0;
    reqAddr   = '0;
    slowRead  = 1'b0;
    cfgWrEn   = 1'b0;
    cfgWrData = '0;
    enMode    = 1'b1;
    slowMode  = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(cfgRdData == 8'h20, "R1", "control register reset", int'(cfgRdData), 32'h20);
    chk(pairWrite == 1'b0, "R1", "pairWrite reset", int'(pairWrite), 0);
    chk(rspValid == 1'b0, "R1", "rspValid idle", int'(rspValid), 0);
    chk(flRead == 1'b0, "R1", "flRead idle", int'(flRead), 0);

    // R2 / R3 control register
    cfgWrite(8'hFF);
    #1;
    chk(cfgRdData == 8'h21, "R2", "reserved bits ignored", int'(cfgRdData), 32'h21);
    chk(pairWrite == 1'b1, "R3", "pairWrite set", int'(pairWrite), 1);
    idle(3);
    #1;
    chk(cfgRdData == 8'h21, "R2", "register holds", int'(cfgRdData), 32'h21);
    cfgWrite(8'hDE);
    #1;
    chk(cfgRdData == 8'h00, "R2", "live bits cleared", int'(cfgRdData), 0);
    chk(pairWrite == 1'b0, "R3", "pairWrite cleared", int'(pairWrite), 0);
    cfgWrite(8'h20);

    // fast latency, enabled
    setMode(1'b1, 1'b0);
    runLinear(10'h040, 12, "R6");
    idle(1);
    runLinear(10'h091, 8, "R8");

    // slow latency, enabled
    setMode(1'b1, 1'b1);
    runLinear(10'h100, 10, "R6");
    runLinear(10'h1A3, 8, "R8");   // also abandons an in-progress prefetch (R7)
    idle(2);
    runLinear(10'h020, 3, "R6");
    runLinear(10'h150, 4, "R7");   // branch during the two-cycle prefetch

    // disabled, both latencies
    setMode(1'b0, 1'b0);
    runLinear(10'h300, 6, "R9");
    setMode(1'b0, 1'b1);
    runLinear(10'h311, 5, "R9");

    // random segments
    for (int seg = 0; seg < 200; seg++) begin
      logic [ADDR_W-1:0] a;
      int len;
      if ($urandom % 8 == 0) setMode(1'($urandom), 1'($urandom));
      a   = ADDR_W'($urandom);
      len = 1 + int'($urandom % 6);
      for (int i = 0; i < len; i++) begin
        if ($urandom % 4 == 0) idle(1);
        fetchByte(a + ADDR_W'(i), slowMode ? 2 : 1, (!enMode && i > 0), "R9");
      end
    end

    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule